// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for a synchronous memory that serves accesses in bursts of four beats. On an enabled clock edge with the step/load control low, it captures a full base address and starts a new burst at it. With the control high, it moves to the next beat. Only the two lowest address bits change during a burst. They follow either a linear count or an XOR-interleaved count, and a static order input picks which one.

An active-low clock enable gates every state change. While it is high the sequencer ignores the clock, so the current address and the indication are held and the previous cycle is extended. After reset no access is in progress, and step requests do nothing until a load arrives. The address output and the load indication are both registered.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets `addr_out` to zero and `was_load` to 0, and leaves no access in progress.
- R2: On a rising edge with `clk_en_n` low and `advance` low, `addr_out` takes the value of `addr_in` in full, and `was_load` becomes 1 on the same edge.
- R3: With `order_sel` = 0 (linear), the low two bits of beat n of a burst (n = 0 on the load edge) equal (base + n) mod 4.
- R4: With `order_sel` = 1 (interleaved), the low two bits of beat n equal base XOR n.
- R5: During stepping, the bits of `addr_out` above bit 1 keep the value captured at the load, with no carry from the low bits.
- R6: The edge after beat 3 returns the burst to beat 0, that is, to the loaded base address.
- R7: While `clk_en_n` is high, `addr_out` and `was_load` hold their values whatever `advance`, `order_sel` and `addr_in` do, and the burst resumes at the next beat once the enable returns.
- R8: A step request (`advance` high) with no access in progress, after reset and before any load, leaves `addr_out` unchanged.
- R9: On an enabled edge with `advance` high, `was_load` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| advance | input | 1 | 1 steps the burst, 0 loads a new base address |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Base address captured on a load |
| addr_out | output | ADDR_W | Current word address (registered) |
| was_load | output | 1 | 1 when the last enabled edge was a load |

## Verification
Every combination of the two low base bits runs in both orders, combined with upper-bit patterns of all zeros, all ones and alternating ones and zeros. This separates an adder from an XOR, shows any carry into the upper field, and shows a wrong wrap on the fifth and sixth beats. A burst is frozen in the middle by the clock enable while the other inputs change, which shows that nothing leaks through the gate and that stepping resumes at the right beat. Step requests right after reset, both before any load and after a reset in the middle of a burst, show whether the block correctly refuses to run without a loaded base.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/bseq_beat_counter.sv
module bseq_beat_counter #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  output logic [BURST_W-1:0] beat_next
);

  logic [BURST_W-1:0] beat_q;

  always_comb begin
    if (clear)
      beat_next = '0;
    else if (step)
      beat_next = beat_q + BURST_W'(1);
    else
      beat_next = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      beat_q <= '0;
    else
      beat_q <= beat_next;
  end

endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_next,
  output logic              live_q
);

  logic [ADDR_W-1:0] base_q;

  assign base_next = load ? addr_in : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      live_q <= 1'b0;
    end else begin
      base_q <= base_next;
      if (load)
        live_q <= 1'b1;
    end
  end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               order_sel,
  input  logic [BURST_W-1:0] base_lo,
  input  logic [BURST_W-1:0] beat,
  output logic [BURST_W-1:0] addr_lo
);

  logic [BURST_W-1:0] lin_lo;
  logic [BURST_W-1:0] ilv_lo;

  // Linear order wraps inside the burst field; the truncated sum drops the carry.
  assign lin_lo = base_lo + beat;

  // Interleaved order flips the base bits selected by the beat count.
  genvar gi;
  generate
    for (gi = 0; gi < BURST_W; gi++) begin : g_ilv
      assign ilv_lo[gi] = base_lo[gi] ^ beat[gi];
    end
  endgenerate

  always_comb begin
    unique case (burst_order_e'(order_sel))
      ORDER_LINEAR:     addr_lo = lin_lo;
      ORDER_INTERLEAVE: addr_lo = ilv_lo;
      default:          addr_lo = lin_lo;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              was_load
);

  localparam int UPPER_W = ADDR_W - BURST_W;

  logic               enabled;
  logic               do_load;
  logic               do_step;
  logic               live_q;
  logic [ADDR_W-1:0]  base_next;
  logic [BURST_W-1:0] beat_next;
  logic [BURST_W-1:0] lo_next;
  logic [ADDR_W-1:0]  addr_q;
  logic               was_load_q;

  assign enabled = ~clk_en_n;
  assign do_load = enabled & ~advance;
  assign do_step = enabled & advance & live_q;

  bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .load      (do_load),
    .addr_in   (addr_in),
    .base_next (base_next),
    .live_q    (live_q)
  );

  bseq_beat_counter #(.BURST_W(BURST_W)) u_beat (
    .clk       (clk),
    .rst       (rst),
    .clear     (do_load),
    .step      (do_step),
    .beat_next (beat_next)
  );

  bseq_order_map #(.BURST_W(BURST_W)) u_map (
    .order_sel (order_sel),
    .base_lo   (base_next[BURST_W-1:0]),
    .beat      (beat_next),
    .addr_lo   (lo_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      was_load_q <= 1'b0;
    end else begin
      if (do_load || do_step)
        addr_q <= {base_next[ADDR_W-1 -: UPPER_W], lo_next};
      if (enabled)
        was_load_q <= ~advance;
    end
  end

  assign addr_out = addr_q;
  assign was_load = was_load_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              advance,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              was_load,
  input logic              live
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && !was_load && !live);

  a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !advance) |=> (addr_out == $past(addr_in)) && was_load);

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && advance && live && !order_sel) |=>
      addr_out[BURST_W-1:0] == BURST_W'($past(addr_out[BURST_W-1:0]) + BURST_W'(1)));

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && advance) |=>
      addr_out[ADDR_W-1:BURST_W] == $past(addr_out[ADDR_W-1:BURST_W]));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(addr_out) && $stable(was_load));

  a_r8_idle_step: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && advance && !live) |=> $stable(addr_out));

  a_r9_step_flag: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && advance) |=> !was_load);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W  (ADDR_W),
  .BURST_W (BURST_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en_n  (clk_en_n),
  .advance   (advance),
  .order_sel (order_sel),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .was_load  (was_load),
  .live      (live_q)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

  localparam int AW = 8;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          advance = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          was_load;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) uut (
    .clk       (clk),
    .rst       (rst),
    .clk_en_n  (clk_en_n),
    .advance   (advance),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .was_load  (was_load)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, int n, logic ilv);
    int lo;
    if (ilv) lo = (int'(base[1:0]) ^ n) & 3;
    else     lo = (int'(base[1:0]) + n) % 4;
    return {base[AW-1:2], 2'(lo)};
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, then look just after the next rising edge.
  task automatic cycle(logic cen_n, logic adv, logic [AW-1:0] a);
    @(negedge clk);
    clk_en_n = cen_n;
    advance  = adv;
    addr_in  = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    logic [5:0] his [3];
    his[0] = 6'h00; his[1] = 6'h3F; his[2] = 6'h15;

    rst = 1'b1;
    repeat (2) cycle(1'b0, 1'b1, 8'hA7);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset addr", addr_out, '0);
    chk("R1 reset flag", {7'b0, was_load}, '0);

    // R8: stepping with nothing loaded
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b1, 8'h5C);
      chk("R8 idle step addr", addr_out, '0);
      chk("R9 idle step flag", {7'b0, was_load}, '0);
    end

    // R2..R6, R9 sweep over order, low base bits and upper patterns
    for (int m = 0; m < 2; m++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int h = 0; h < 3; h++) begin
          base = {his[h], 2'(lo)};
          @(negedge clk); order_sel = m[0];
          cycle(1'b0, 1'b0, base);
          chk("R2 load addr", addr_out, base);
          chk("R2 load flag", {7'b0, was_load}, 8'h01);
          for (int n = 1; n <= 6; n++) begin
            cycle(1'b0, 1'b1, ~base);
            if (n >= 4)
              chk("R6 wrap", addr_out, expect_addr(base, n % 4, m[0]));
            else if (m == 0)
              chk("R3 linear beat", addr_out, expect_addr(base, n, 1'b0));
            else
              chk("R4 interleaved beat", addr_out, expect_addr(base, n, 1'b1));
            chk("R5 upper bits", {2'b0, addr_out[AW-1:2]}, {2'b0, his[h]});
            chk("R9 step flag", {7'b0, was_load}, '0);
          end
        end
      end
    end

    // R7: freeze after a load, then in the middle of a burst
    @(negedge clk); order_sel = 1'b0;
    base = 8'hC6;
    cycle(1'b0, 1'b0, base);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); order_sel = k[0];
      cycle(1'b1, k[1], 8'h33);
      chk("R7 hold after load addr", addr_out, base);
      chk("R7 hold after load flag", {7'b0, was_load}, 8'h01);
    end
    @(negedge clk); order_sel = 1'b0;
    cycle(1'b0, 1'b1, 8'h00);
    chk("R3 beat1 before freeze", addr_out, expect_addr(base, 1, 1'b0));
    for (int k = 0; k < 4; k++) begin
      cycle(1'b1, k[0], 8'h9D);
      chk("R7 hold mid burst addr", addr_out, expect_addr(base, 1, 1'b0));
      chk("R7 hold mid burst flag", {7'b0, was_load}, '0);
    end
    cycle(1'b0, 1'b1, 8'h00);
    chk("R7 resume beat2", addr_out, expect_addr(base, 2, 1'b0));

    // R1/R8: reset in the middle of a burst, then step without a load
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid burst reset", addr_out, '0);
    cycle(1'b0, 1'b1, 8'h11);
    chk("R8 step after reset", addr_out, '0);
    cycle(1'b0, 1'b0, 8'h4B);
    chk("R2 reload after reset", addr_out, 8'h4B);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule